// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block steps an 8-bit microcontroller core through taking an interrupt and returning from it, with a fixed cost in clock cycles. When an enabled request is pending and the global enable is set, it waits for the running instruction to retire. It then saves the return address as three bytes on a byte stack that grows toward lower addresses. It moves the stack pointer, clears the global enable and hands the vector to the program counter.

A return request runs the same steps in reverse. Three bytes are read back, the stack pointer rises by three, the saved address is reloaded and the global enable is set again. If the core is asleep when the request is taken, entry gains a fixed wake penalty ahead of the stacking steps.

The block owns the stack pointer and drives a byte-wide stack memory port. That memory returns read data one cycle after the read strobe. While a sequence runs, `busy` holds instruction fetch. Decode, the register file and priority choice between sources belong to the surrounding core.

Top module: `isr_sequencer`

## Requirements
- R1: A synchronous active-low reset returns the block to idle and clears any partial sequence. It sets `busy`=0, `gie`=0, `sp_out`=`SP_RESET`, and leaves no memory strobe and no `pc_load`.
- R2: A request is taken only in idle, and only when `gie`=1, `irq_pending`=1, the block is armed, and either `insn_done`=1 or `core_asleep`=1. While an instruction is still running (`insn_done`=0, awake), or while `gie`=0, `busy` stays low.
- R3: For an awake entry, counting the accepting clock edge as edge 0, `busy` is high in cycles 1 to 5. In cycle 5, `pc_load`=1 and `irq_ack`=1 with `pc_new` equal to the vector sampled at acceptance, and `gie` reads 0 from cycle 6.
- R4: In entry cycles 1, 2 and 3 the block writes PC bits [7:0], [15:8] and [23:16] (zero-extended) to addresses SP, SP-1 and SP-2. SP here is the pointer at acceptance. `sp_out` reads SP-3 once the sequence ends.
- R5: An entry taken while `core_asleep`=1 first spends 5 wake cycles. Its writes fall in cycles 6 to 8, and its vector load falls in cycle 10.
- R6: A `reti_req` in idle reads SP+1, SP+2 and SP+3 in cycles 1 to 3. In cycle 5 it loads `pc_new` = {byte at SP+1, byte at SP+2, byte at SP+3}, with `irq_ack`=0. Afterwards `sp_out` reads SP+3 and `gie` reads 1.
- R7: After a return, no request is taken until one `insn_done` pulse has been seen in idle. A request at the first instruction boundary after the return is therefore deferred to the next boundary.
- R8: `reti_req` and `irq_pending` are ignored while `busy`=1. If both a return and an acceptable request arrive in the same idle cycle, the return is performed.
- R9: `gie_set` sampled in idle makes `gie` read 1 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pending | input | 1 | An enabled interrupt source is pending |
| irq_vector | input | PC_W | Vector address of the pending source |
| insn_done | input | 1 | Current instruction retires this cycle |
| core_asleep | input | 1 | Core is in a sleep mode |
| reti_req | input | 1 | Return-from-interrupt request |
| gie_set | input | 1 | Request to set the global enable |
| pc_in | input | PC_W | Return address to save |
| mem_rdata | input | 8 | Stack read data, one cycle after `mem_re` |
| mem_addr | output | SP_W | Stack memory address |
| mem_wdata | output | 8 | Stack write byte |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe |
| sp_out | output | SP_W | Current stack pointer |
| pc_new | output | PC_W | Address for the program counter, valid with `pc_load` |
| pc_load | output | 1 | Load `pc_new` into the program counter |
| irq_ack | output | 1 | Vector load of an entry (clears the source) |
| gie | output | 1 | Global interrupt enable |
| busy | output | 1 | Sequence in progress; stall fetch |

## Verification
Take the clock edge that samples the stimulus as edge 0. An awake entry then writes in cycles 1 to 3 and loads the vector in cycle 5, a sleeping entry shifts both by 5 cycles, and a return reads in cycles 1 to 3 and reloads in cycle 5. For each stimulus, the driver records the cycle number each write, read and load is due, together with its address and data. The monitor samples on the falling edge, takes the oldest pending item of each kind and compares its cycle, address and data. Any strobe with no matching item fails, and so does any item left over at the end. Deferred and ignored requests are checked by looking at `busy` one cycle after the edge that would have taken them.

// File: rtl/isr_seq_pkg.sv
// Shared types for the interrupt entry/return sequencer.
package isr_seq_pkg;

    // Sequencer phases; one clock per phase except WAKE, PUSH and POP,
    // which repeat under the step counter.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_PUSH,
        ST_SPADJ,
        ST_VEC,
        ST_POP,
        ST_POPSP,
        ST_RET
    } seq_state_t;

endpackage

// File: rtl/isr_seq_ctrl.sv
// Phase controller: decides acceptance of interrupts and returns, walks
// the phases and holds the global enable and the re-arm flag.
// Assumes: WAKE_CYCLES >= 1, PC_BYTES >= 1, and that insn_done is only
// meaningful while idle (fetch is stalled otherwise).
module isr_seq_ctrl
    import isr_seq_pkg::*;
#(
    parameter int PC_BYTES    = 3,
    parameter int WAKE_CYCLES = 5,
    parameter int CNT_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_pending,
    input  logic             insn_done,
    input  logic             core_asleep,
    input  logic             reti_req,
    input  logic             gie_set,
    output seq_state_t       state,
    output logic [CNT_W-1:0] step,
    output logic             accept,
    output logic             gie
);

    localparam logic [CNT_W-1:0] LAST_WAKE = CNT_W'(WAKE_CYCLES - 1);
    localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(PC_BYTES - 1);

    logic       armed;
    logic       take_ret;
    seq_state_t state_d;
    logic [CNT_W-1:0] step_d;

    // Start conditions; a return outranks an interrupt in the same cycle.
    always_comb begin
        take_ret = (state == ST_IDLE) && reti_req;
        accept   = (state == ST_IDLE) && !reti_req && gie && irq_pending &&
                   armed && (insn_done || core_asleep);
    end

    // Next phase and step counter.
    always_comb begin
        state_d = state;
        step_d  = step;
        case (state)
            ST_IDLE: begin
                step_d = '0;
                if (take_ret)    state_d = ST_POP;
                else if (accept) state_d = core_asleep ? ST_WAKE : ST_PUSH;
            end
            ST_WAKE: begin
                if (step == LAST_WAKE) begin
                    state_d = ST_PUSH;
                    step_d  = '0;
                end else begin
                    step_d = step + 1'b1;
                end
            end
            ST_PUSH: begin
                if (step == LAST_BYTE) begin
                    state_d = ST_SPADJ;
                    step_d  = '0;
                end else begin
                    step_d = step + 1'b1;
                end
            end
            ST_SPADJ: state_d = ST_VEC;
            ST_VEC:   state_d = ST_IDLE;
            ST_POP: begin
                if (step == LAST_BYTE) begin
                    state_d = ST_POPSP;
                    step_d  = '0;
                end else begin
                    step_d = step + 1'b1;
                end
            end
            ST_POPSP: state_d = ST_RET;
            ST_RET:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Phase and step registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            step  <= '0;
        end else begin
            state <= state_d;
            step  <= step_d;
        end
    end

    // Global enable: cleared at the vector load, set at the return load or on request in idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                                gie <= 1'b0;
        else if (state == ST_VEC)                  gie <= 1'b0;
        else if (state == ST_RET)                  gie <= 1'b1;
        else if (state == ST_IDLE && gie_set)      gie <= 1'b1;
    end

    // Re-arm flag: one retired instruction is required after each return.
    always_ff @(posedge clk) begin
        if (!rst_n)                                armed <= 1'b1;
        else if (state == ST_RET)                  armed <= 1'b0;
        else if (state == ST_IDLE && insn_done)    armed <= 1'b1;
    end

endmodule

// File: rtl/isr_seq_stack.sv
// Stack pointer and stack address generation. Push k writes SP-k, pop k
// reads SP+1+k; the pointer itself moves once per sequence by PC_BYTES.
// Assumes the pointer wraps modulo 2**SP_W.
module isr_seq_stack
    import isr_seq_pkg::*;
#(
    parameter int              SP_W     = 16,
    parameter logic [SP_W-1:0] SP_RESET = 16'h08FF,
    parameter int              PC_BYTES = 3,
    parameter int              CNT_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_state_t       state,
    input  logic [CNT_W-1:0] step,
    output logic [SP_W-1:0]  mem_addr,
    output logic             mem_we,
    output logic             mem_re,
    output logic [SP_W-1:0]  sp
);

    localparam logic [SP_W-1:0] FRAME = SP_W'(PC_BYTES);

    // Address and strobes for the current phase.
    always_comb begin
        mem_we   = (state == ST_PUSH);
        mem_re   = (state == ST_POP);
        mem_addr = sp;
        if (state == ST_PUSH)     mem_addr = sp - SP_W'(step);
        else if (state == ST_POP) mem_addr = sp + SP_W'(step) + 1'b1;
    end

    // Stack pointer: single adjustment per sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)                  sp <= SP_RESET;
        else if (state == ST_SPADJ)  sp <= sp - FRAME;
        else if (state == ST_POPSP)  sp <= sp + FRAME;
    end

endmodule

// File: rtl/isr_seq_frame.sv
// Data path for the saved frame: latches the return address and vector at
// acceptance, serves push bytes low first, and collects popped bytes
// (high first) into the address to restore.
// Assumes stack read data arrives one cycle after the read strobe.
module isr_seq_frame
    import isr_seq_pkg::*;
#(
    parameter int PC_W  = 22,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  seq_state_t       state,
    input  logic [CNT_W-1:0] step,
    input  logic [PC_W-1:0]  pc_in,
    input  logic [PC_W-1:0]  irq_vector,
    input  logic [7:0]       mem_rdata,
    output logic [7:0]       mem_wdata,
    output logic [PC_W-1:0]  pc_new
);

    localparam int PC_BYTES = (PC_W + 7) / 8;
    localparam int PAD_W    = PC_BYTES * 8;

    logic [PAD_W-1:0] save_q;
    logic [PAD_W-1:0] pop_q;
    logic [PAD_W-1:0] save_sh;
    logic [PC_W-1:0]  vec_q;
    logic             capture;

    // Capture points for the delayed read data.
    always_comb begin
        capture = ((state == ST_POP) && (step != '0)) || (state == ST_POPSP);
    end

    // Byte selection for the push in progress.
    always_comb begin
        save_sh   = save_q >> {step, 3'b000};
        mem_wdata = save_sh[7:0];
    end

    // Return address and vector captured at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            save_q <= '0;
            vec_q  <= '0;
        end else if (accept) begin
            save_q <= PAD_W'(pc_in);
            vec_q  <= irq_vector;
        end
    end

    // Popped bytes shift in from the low end, so the first byte read ends up highest.
    generate
        if (PC_BYTES > 1) begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n)       pop_q <= '0;
                else if (capture) pop_q <= {pop_q[PAD_W-9:0], mem_rdata};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n)       pop_q <= '0;
                else if (capture) pop_q <= mem_rdata;
            end
        end
    endgenerate

    // Address offered to the program counter.
    always_comb begin
        pc_new = (state == ST_VEC) ? vec_q : pop_q[PC_W-1:0];
    end

endmodule

// File: rtl/isr_sequencer.sv
// Interrupt entry and return sequencer, top level.
// Awake entry: PC_BYTES push cycles, one pointer cycle, one vector cycle.
// Return: PC_BYTES read cycles, one pointer/last-capture cycle, one load cycle.
// Assumes the stack memory has one cycle of read latency.
module isr_sequencer
    import isr_seq_pkg::*;
#(
    parameter int              PC_W        = 22,
    parameter int              SP_W        = 16,
    parameter logic [SP_W-1:0] SP_RESET    = 16'h08FF,
    parameter int              WAKE_CYCLES = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq_pending,
    input  logic [PC_W-1:0] irq_vector,
    input  logic            insn_done,
    input  logic            core_asleep,
    input  logic            reti_req,
    input  logic            gie_set,
    input  logic [PC_W-1:0] pc_in,
    input  logic [7:0]      mem_rdata,
    output logic [SP_W-1:0] mem_addr,
    output logic [7:0]      mem_wdata,
    output logic            mem_we,
    output logic            mem_re,
    output logic [SP_W-1:0] sp_out,
    output logic [PC_W-1:0] pc_new,
    output logic            pc_load,
    output logic            irq_ack,
    output logic            gie,
    output logic            busy
);

    localparam int PC_BYTES = (PC_W + 7) / 8;
    localparam int MAX_CNT  = (WAKE_CYCLES > PC_BYTES) ? WAKE_CYCLES : PC_BYTES;
    localparam int CNT_W    = $clog2(MAX_CNT + 1);

    seq_state_t       state;
    logic [CNT_W-1:0] step;
    logic             accept;

    isr_seq_ctrl #(
        .PC_BYTES    (PC_BYTES),
        .WAKE_CYCLES (WAKE_CYCLES),
        .CNT_W       (CNT_W)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_pending (irq_pending),
        .insn_done   (insn_done),
        .core_asleep (core_asleep),
        .reti_req    (reti_req),
        .gie_set     (gie_set),
        .state       (state),
        .step        (step),
        .accept      (accept),
        .gie         (gie)
    );

    isr_seq_stack #(
        .SP_W     (SP_W),
        .SP_RESET (SP_RESET),
        .PC_BYTES (PC_BYTES),
        .CNT_W    (CNT_W)
    ) stack_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .step     (step),
        .mem_addr (mem_addr),
        .mem_we   (mem_we),
        .mem_re   (mem_re),
        .sp       (sp_out)
    );

    isr_seq_frame #(
        .PC_W  (PC_W),
        .CNT_W (CNT_W)
    ) frame_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .state      (state),
        .step       (step),
        .pc_in      (pc_in),
        .irq_vector (irq_vector),
        .mem_rdata  (mem_rdata),
        .mem_wdata  (mem_wdata),
        .pc_new     (pc_new)
    );

    // Edge outputs decoded from the phase.
    always_comb begin
        busy    = (state != ST_IDLE);
        pc_load = (state == ST_VEC) || (state == ST_RET);
        irq_ack = (state == ST_VEC);
    end

endmodule

// File: rtl/isr_sequencer_chk.sv
// Port-level temporal checks for the sequencer, attached by bind.
module isr_sequencer_chk #(
    parameter int SP_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            gie,
    input logic            pc_load,
    input logic            irq_ack,
    input logic            mem_we,
    input logic            mem_re,
    input logic [SP_W-1:0] sp_out
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !gie && !mem_we && !mem_re && !pc_load));

    // R3
    load_in_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> busy);

    // R3
    load_ends_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !busy);

    // R3
    ack_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !gie);

    // R4
    mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> (busy && !(mem_we && mem_re)));

    // R4
    sp_moves_in_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sp_out) |-> $past(busy));

    // R6
    ret_sets_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && !irq_ack) |=> gie);

endmodule

bind isr_sequencer isr_sequencer_chk #(.SP_W(SP_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .gie     (gie),
    .pc_load (pc_load),
    .irq_ack (irq_ack),
    .mem_we  (mem_we),
    .mem_re  (mem_re),
    .sp_out  (sp_out)
);

// File: tb/isr_sequencer_tb_top.sv
// Scoreboard bench: driver tasks queue expected writes, reads and loads
// with their due cycle; a falling-edge monitor compares them.
module isr_sequencer_tb_top;

    localparam int              PC_W  = 22;
    localparam int              SP_W  = 16;
    localparam logic [SP_W-1:0] SPR   = 16'h08FF;

    typedef struct {
        int          cyc;
        logic [15:0] addr;
        logic [23:0] val;
        bit          ack;
        string       req;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            irq_pending = 1'b0;
    logic [PC_W-1:0] irq_vector = '0;
    logic            insn_done = 1'b0;
    logic            core_asleep = 1'b0;
    logic            reti_req = 1'b0;
    logic            gie_set = 1'b0;
    logic [PC_W-1:0] pc_in = '0;
    logic [7:0]      mem_rdata = '0;
    logic [SP_W-1:0] mem_addr;
    logic [7:0]      mem_wdata;
    logic            mem_we, mem_re;
    logic [SP_W-1:0] sp_out;
    logic [PC_W-1:0] pc_new;
    logic            pc_load, irq_ack, gie, busy;

    logic [7:0] mem [256];
    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    exp_t qw[$];
    exp_t qr[$];
    exp_t ql[$];

    always #2 clk = ~clk;

    isr_sequencer #(.PC_W(PC_W), .SP_W(SP_W), .SP_RESET(SPR), .WAKE_CYCLES(5)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_pending(irq_pending), .irq_vector(irq_vector),
        .insn_done(insn_done), .core_asleep(core_asleep), .reti_req(reti_req),
        .gie_set(gie_set), .pc_in(pc_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re), .sp_out(sp_out),
        .pc_new(pc_new), .pc_load(pc_load), .irq_ack(irq_ack), .gie(gie), .busy(busy)
    );

    // Cycle counter and stack memory model with one cycle of read latency.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_we === 1'b1) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_re === 1'b1) mem_rdata <= mem[mem_addr[7:0]];
    end

    task automatic check(input bit ok, input string req, input string msg);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    // Driver side: expected items for an entry accepted at the edge after cycle c.
    task automatic exp_entry(input int c, input logic [15:0] sp, input logic [PC_W-1:0] pc,
                             input logic [PC_W-1:0] vec, input bit wake);
        int off = wake ? 5 : 0;
        logic [23:0] p = 24'(pc);
        for (int k = 0; k < 3; k++)
            qw.push_back('{c + 1 + off + k, sp - 16'(k), 24'(p[8*k +: 8]), 1'b0,
                           wake ? "R5" : "R4"});
        ql.push_back('{c + 5 + off, 16'h0, 24'(vec), 1'b1, wake ? "R5" : "R3"});
    endtask

    task automatic exp_return(input int c, input logic [15:0] sp, input logic [PC_W-1:0] pc);
        for (int k = 0; k < 3; k++)
            qr.push_back('{c + 1 + k, sp + 16'(k + 1), 24'h0, 1'b0, "R6"});
        ql.push_back('{c + 5, 16'h0, 24'(pc), 1'b0, "R6"});
    endtask

    // Monitor side: compare strobes against the oldest expected item.
    always @(negedge clk) begin
        exp_t e;
        if (mem_we === 1'b1) begin
            if (qw.size() == 0) check(0, "R4", $sformatf("unexpected write act addr=%h exp none", mem_addr));
            else begin
                e = qw.pop_front();
                check(cyc == e.cyc && mem_addr == e.addr && mem_wdata == e.val[7:0], e.req,
                      $sformatf("write act cyc=%0d addr=%h data=%h exp cyc=%0d addr=%h data=%h",
                                cyc, mem_addr, mem_wdata, e.cyc, e.addr, e.val[7:0]));
            end
        end
        if (mem_re === 1'b1) begin
            if (qr.size() == 0) check(0, "R6", $sformatf("unexpected read act addr=%h exp none", mem_addr));
            else begin
                e = qr.pop_front();
                check(cyc == e.cyc && mem_addr == e.addr, e.req,
                      $sformatf("read act cyc=%0d addr=%h exp cyc=%0d addr=%h",
                                cyc, mem_addr, e.cyc, e.addr));
            end
        end
        if (pc_load === 1'b1) begin
            if (ql.size() == 0) check(0, "R3", $sformatf("unexpected load act pc=%h exp none", pc_new));
            else begin
                e = ql.pop_front();
                check(cyc == e.cyc && pc_new == e.val[PC_W-1:0] && irq_ack == e.ack, e.req,
                      $sformatf("load act cyc=%0d pc=%h ack=%b exp cyc=%0d pc=%h ack=%b",
                                cyc, pc_new, irq_ack, e.cyc, e.val[PC_W-1:0], e.ack));
            end
        end
    end

    // Wait out a sequence already started; returns the number of busy cycles.
    task automatic run_seq(output int n);
        @(negedge clk);
        irq_pending = 0; insn_done = 0; reti_req = 0; gie_set = 0;
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_gie();
        gie_set = 1;
        @(negedge clk);
        gie_set = 0;
    endtask

    task automatic pulse_insn();
        insn_done = 1;
        @(negedge clk);
        insn_done = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(0, "R1", "watchdog act expired exp finished");
        finish_run();
    end

    initial begin
        int n;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !gie && !mem_we && !mem_re && !pc_load && sp_out == SPR, "R1",
              $sformatf("reset act busy=%b gie=%b sp=%h exp 0 0 %h", busy, gie, sp_out, SPR));
        rst_n = 1;
        @(negedge clk);

        // R2: enable clear blocks acceptance
        irq_pending = 1; insn_done = 1; pc_in = 22'h000111; irq_vector = 22'h000004;
        @(negedge clk);
        irq_pending = 0; insn_done = 0;
        check(!busy, "R2", $sformatf("gie=0 act busy=%b exp 0", busy));

        // R9: set the enable
        pulse_gie();
        check(gie, "R9", $sformatf("gie_set act gie=%b exp 1", gie));

        // R2: multi-cycle instruction still running
        irq_pending = 1; pc_in = 22'h2A1B3C; irq_vector = 22'h000040;
        repeat (3) @(negedge clk);
        check(!busy, "R2", $sformatf("no boundary act busy=%b exp 0", busy));

        // R3 R4 R8: awake entry, return request during it is ignored
        insn_done = 1;
        exp_entry(cyc, SPR, 22'h2A1B3C, 22'h000040, 0);
        @(negedge clk);
        irq_pending = 0; insn_done = 0; reti_req = 1;
        n = 0;
        while (busy) begin
            n++;
            if (n == 2) reti_req = 0;
            @(negedge clk);
        end
        reti_req = 0;
        check(n == 5, "R3", $sformatf("entry busy act %0d exp 5", n));
        check(!gie, "R3", $sformatf("after entry act gie=%b exp 0", gie));
        check(sp_out == SPR - 16'd3, "R4", $sformatf("sp act %h exp %h", sp_out, SPR - 16'd3));
        check(mem[8'hFF] == 8'h3C && mem[8'hFE] == 8'h1B && mem[8'hFD] == 8'h2A, "R4",
              $sformatf("frame act %h %h %h exp 3c 1b 2a", mem[8'hFF], mem[8'hFE], mem[8'hFD]));
        check(ql.size() == 0 && qr.size() == 0, "R8", "reti during entry act extra items exp none");

        // R6: return
        reti_req = 1;
        exp_return(cyc, SPR - 16'd3, 22'h2A1B3C);
        run_seq(n);
        check(n == 5, "R6", $sformatf("return busy act %0d exp 5", n));
        check(sp_out == SPR && gie, "R6", $sformatf("after return act sp=%h gie=%b exp %h 1", sp_out, gie, SPR));

        // R7: first boundary after return is not taken
        irq_pending = 1; insn_done = 1; pc_in = 22'h156789; irq_vector = 22'h000008;
        @(negedge clk);
        insn_done = 0;
        check(!busy, "R7", $sformatf("boundary after return act busy=%b exp 0", busy));
        @(negedge clk);
        check(!busy, "R7", $sformatf("no boundary act busy=%b exp 0", busy));
        insn_done = 1;
        exp_entry(cyc, SPR, 22'h156789, 22'h000008, 0);
        run_seq(n);
        check(n == 5 && sp_out == SPR - 16'd3, "R7", $sformatf("second boundary act busy=%0d sp=%h exp 5 %h", n, sp_out, SPR - 16'd3));
        reti_req = 1;
        exp_return(cyc, SPR - 16'd3, 22'h156789);
        run_seq(n);
        pulse_insn();

        // R5: entry from sleep
        core_asleep = 1; irq_pending = 1; pc_in = 22'h30F00D; irq_vector = 22'h000010;
        exp_entry(cyc, SPR, 22'h30F00D, 22'h000010, 1);
        run_seq(n);
        core_asleep = 0;
        check(n == 10, "R5", $sformatf("sleep entry busy act %0d exp 10", n));
        reti_req = 1;
        exp_return(cyc, SPR - 16'd3, 22'h30F00D);
        run_seq(n);
        check(sp_out == SPR, "R6", $sformatf("after sleep return act sp=%h exp %h", sp_out, SPR));
        pulse_insn();

        // R8: nested entry, then return wins over a same-cycle request
        irq_pending = 1; insn_done = 1; pc_in = 22'h0ABCDE; irq_vector = 22'h000040;
        exp_entry(cyc, SPR, 22'h0ABCDE, 22'h000040, 0);
        run_seq(n);
        pulse_gie();
        irq_pending = 1; insn_done = 1; pc_in = 22'h112233; irq_vector = 22'h000080;
        exp_entry(cyc, SPR - 16'd3, 22'h112233, 22'h000080, 0);
        run_seq(n);
        check(sp_out == SPR - 16'd6, "R4", $sformatf("nested sp act %h exp %h", sp_out, SPR - 16'd6));
        pulse_gie();
        reti_req = 1; irq_pending = 1; insn_done = 1; pc_in = 22'h3FFFFF;
        exp_return(cyc, SPR - 16'd6, 22'h112233);
        run_seq(n);
        check(gie && sp_out == SPR - 16'd3, "R8", $sformatf("priority act gie=%b sp=%h exp 1 %h", gie, sp_out, SPR - 16'd3));
        reti_req = 1;
        exp_return(cyc, SPR - 16'd3, 22'h0ABCDE);
        run_seq(n);
        check(sp_out == SPR, "R6", $sformatf("outer return act sp=%h exp %h", sp_out, SPR));
        pulse_insn();

        // R1: reset in the middle of an entry
        irq_pending = 1; insn_done = 1; pc_in = 22'h2468AC; irq_vector = 22'h000020;
        exp_entry(cyc, SPR, 22'h2468AC, 22'h000020, 0);
        @(negedge clk);
        irq_pending = 0; insn_done = 0;
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        qw.delete(); ql.delete();
        rst_n = 1;
        check(!busy && !gie && sp_out == SPR && !mem_we, "R1",
              $sformatf("mid reset act busy=%b gie=%b sp=%h exp 0 0 %h", busy, gie, sp_out, SPR));
        repeat (3) @(negedge clk);
        check(!busy && !pc_load, "R1", $sformatf("after mid reset act busy=%b exp 0", busy));

        check(qw.size() == 0 && qr.size() == 0 && ql.size() == 0, "R3",
              $sformatf("leftover act w=%0d r=%0d l=%0d exp 0", qw.size(), qr.size(), ql.size()));
        finish_run();
    end

endmodule